// File: doc/BRIEF.md
# Key-Guarded System Configuration Registers

This block keeps a small set of system configuration words behind a one-shot unlock key. Software first writes the key value 0xAA to a key slot and then, as its very next bus write, writes a guarded register. Any bus write at all uses up a pending unlock, whatever its address or data. Reads never touch the unlock state, so read-modify-write sequences can read the current word, compute the new one, write the key, and then write the result.

Two words are guarded. The first is a device-configuration word that drives pin-multiplexing and peripheral-enable controls; its top bit is a software-reset control. The second is a clock-divider word for the audio serial interface, which holds its override and polarity controls. A third word is read-only. It reports a chip revision field that is tied at integration time.

Clearing the software-reset bit after it was set raises a single-cycle reset request. The actual pin multiplexing and the reset generator sit outside this block.

Top module: `syscfg_lockreg`

## Requirements
- R1: During reset and after it ends, the device word is DEV_INIT, the divider word is AUD_INIT, the reset request is low, and no unlock is pending; reset also drops any unlock that was armed before it.
- R2: A bus write of the full word 0x000000AA to word address 0 (key slot) arms the unlock.
- R3: A write to word address 1 (device word) takes effect only if the immediately preceding bus write armed the unlock; otherwise the device word keeps its value.
- R4: Any bus write to any address consumes a pending unlock, including writes to unused addresses and to the read-only word.
- R5: A key-slot write of any other value, including 0x1AA, leaves the unlock cleared.
- R6: Word address 2 (audio divider word) is guarded exactly like the device word.
- R7: Word address 3 reads the revision input placed at bits [31:28] with all other bits zero; writes to it have no effect.
- R8: The reset request pulses high for exactly one cycle, in the cycle after an accepted device-word write changes bit 31 from 1 to 0. Writes that set bit 31, keep it at 1, or keep it at 0 raise no request.
- R9: Cycles without a write strobe (reads) do not consume a pending unlock.
- R10: Reads of addresses 1 and 2 return the stored words, and these match the output ports. The key slot and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| rev_id | input | REV_W | Chip revision, tied at integration |
| devcfg_o | output | DATA_W | Device-configuration word |
| audclk_o | output | DATA_W | Audio clock-divider word |
| rst_req_o | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with its defaults: 32-bit data, 4-bit addressing, the reset control at bit 31, and a 4-bit revision at bits 28 to 31 driven with 0xA. Both guarded words are built in their guarded variant. With 4-bit addressing, addresses above the defined four can be reached, so the bench can check that writes to unused addresses still consume the unlock. With the reset control in the top bit, a single write can change the reset control and other bits at the same time, which exercises the set, hold and clear transitions of that bit.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
   // word slots decoded on the bus address
   localparam int unsigned SLOT_KEY = 0;
   localparam int unsigned SLOT_DEV = 1;
   localparam int unsigned SLOT_AUD = 2;
   localparam int unsigned SLOT_SYS = 3;
   // unlock key value
   localparam logic [7:0]  UNLOCK_KEY = 8'hAA;
endpackage

// File: rtl/syscfg_unlock.sv
module syscfg_unlock #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned KEY_SLOT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed
);
   import syscfg_pkg::*;

   localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(KEY_SLOT);
   localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(UNLOCK_KEY);

   logic key_hit;
   assign key_hit = (addr == KEY_ADDR) && (wdata == KEY_WORD);

   // every write replaces the state: only a key write leaves it armed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  armed <= 1'b0;
      else if (we) armed <= key_hit;
   end
endmodule

// File: rtl/syscfg_prot_reg.sv
module syscfg_prot_reg #(
   parameter int unsigned     ADDR_W  = 4,
   parameter int unsigned     DATA_W  = 32,
   parameter int unsigned     SLOT    = 1,
   parameter logic [DATA_W-1:0] INIT  = '0,
   parameter bit              GUARDED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              armed,
   output logic [DATA_W-1:0] q,
   output logic              commit
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SLOT);

   logic hit;
   assign hit = we && (addr == MY_ADDR);

   generate
      if (GUARDED) begin : g_guard
         assign commit = hit && armed;
      end else begin : g_open
         logic unused_armed;
         assign unused_armed = armed;
         assign commit = hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= INIT;
      else if (commit) q <= wdata;
   end
endmodule

// File: rtl/syscfg_swrst_edge.sv
module syscfg_swrst_edge #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned RST_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [DATA_W-1:0] old_q,
   input  logic [DATA_W-1:0] new_d,
   output logic              pulse
);
   logic falling;
   assign falling = commit && old_q[RST_BIT] && !new_d[RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= falling;
   end
endmodule

// File: rtl/syscfg_lockreg.sv
module syscfg_lockreg #(
   parameter int unsigned       ADDR_W   = 4,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       REV_W    = 4,
   parameter int unsigned       REV_LSB  = 28,
   parameter int unsigned       RST_BIT  = 31,
   parameter logic [DATA_W-1:0] DEV_INIT = '0,
   parameter logic [DATA_W-1:0] AUD_INIT = '0,
   parameter bit                AUD_GUARDED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [REV_W-1:0]  rev_id,
   output logic [DATA_W-1:0] devcfg_o,
   output logic [DATA_W-1:0] audclk_o,
   output logic              rst_req_o
);
   import syscfg_pkg::*;

   localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(SLOT_DEV);
   localparam logic [ADDR_W-1:0] A_AUD = ADDR_W'(SLOT_AUD);
   localparam logic [ADDR_W-1:0] A_SYS = ADDR_W'(SLOT_SYS);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8)                begin : g_bad_dw  $error("DATA_W must hold the key"); end
      if (REV_LSB + REV_W > DATA_W)  begin : g_bad_rev $error("revision field exceeds word"); end
      if (RST_BIT >= DATA_W)         begin : g_bad_rst $error("reset bit outside word"); end
      if ((1 << ADDR_W) <= SLOT_SYS) begin : g_bad_aw  $error("ADDR_W too small for slots"); end
   endgenerate

   logic armed;
   logic dev_commit, aud_commit;
   logic [DATA_W-1:0] sys_word;

   syscfg_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_SLOT(SLOT_KEY)) u_unlock (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .armed(armed)
   );

   syscfg_prot_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT(SLOT_DEV),
                     .INIT(DEV_INIT), .GUARDED(1'b1)) u_dev (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .armed(armed), .q(devcfg_o), .commit(dev_commit)
   );

   syscfg_prot_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT(SLOT_AUD),
                     .INIT(AUD_INIT), .GUARDED(AUD_GUARDED)) u_aud (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .armed(armed), .q(audclk_o), .commit(aud_commit)
   );

   syscfg_swrst_edge #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_swrst (
      .clk(clk), .rst_n(rst_n), .commit(dev_commit),
      .old_q(devcfg_o), .new_d(bus_wdata), .pulse(rst_req_o)
   );

   // read-only word: revision placed at its field, rest zero
   assign sys_word = DATA_W'(rev_id) << REV_LSB;

   logic unused_aud_commit;
   assign unused_aud_commit = aud_commit;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_DEV)      bus_rdata = devcfg_o;
      else if (bus_addr == A_AUD) bus_rdata = audclk_o;
      else if (bus_addr == A_SYS) bus_rdata = sys_word;
   end
endmodule

// File: rtl/syscfg_lockreg_chk.sv
module syscfg_lockreg_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned REV_W   = 4,
   parameter int unsigned REV_LSB = 28,
   parameter int unsigned RST_BIT = 31,
   parameter bit          AUD_GUARDED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [REV_W-1:0]  rev_id,
   input logic [DATA_W-1:0] devcfg_o,
   input logic [DATA_W-1:0] audclk_o,
   input logic              rst_req_o
);
   // observer's own record of whether the previous write was the key
   logic prev_key;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_key <= 1'b0;
      else if (bus_we) prev_key <= (bus_addr == ADDR_W'(0)) && (bus_wdata == DATA_W'(8'hAA));
   end

   // R3
   dev_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1) && !prev_key) |=> $stable(devcfg_o));
   // R3
   dev_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1) && prev_key) |=> (devcfg_o == $past(bus_wdata)));
   // R4
   dev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(1)) |=> $stable(devcfg_o));
   // R6
   aud_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (AUD_GUARDED && bus_we && bus_addr == ADDR_W'(2) && !prev_key) |=> $stable(audclk_o));
   // R7
   sys_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3)) |-> (bus_rdata == (DATA_W'(rev_id) << REV_LSB)));
   // R8
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(devcfg_o[RST_BIT]) && !devcfg_o[RST_BIT]));
   // R8
   rst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devcfg_o[RST_BIT]) |-> rst_req_o);
   // R8
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
endmodule

bind syscfg_lockreg syscfg_lockreg_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV_W(REV_W), .REV_LSB(REV_LSB),
   .RST_BIT(RST_BIT), .AUD_GUARDED(AUD_GUARDED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .bus_rdata(bus_rdata), .rev_id(rev_id),
   .devcfg_o(devcfg_o), .audclk_o(audclk_o), .rst_req_o(rst_req_o)
);

// File: tb/syscfg_lockreg_tb_top.sv
module syscfg_lockreg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 34;
   localparam int VW = 78;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  rev_id = 4'hA;
   logic [31:0] devcfg_o, audclk_o;
   logic        rst_req_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   syscfg_lockreg dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .rev_id(rev_id),
      .devcfg_o(devcfg_o), .audclk_o(audclk_o), .rst_req_o(rst_req_o)
   );

   // {we, addr, wdata, read addr, expected read, expected reset request, requirement}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 4'd1, 32'h0000_1234, 4'd1, 32'h0000_0000, 1'b0, 4'd3},  // R3 no key
      {1'b1, 4'd0, 32'h0000_00AA, 4'd0, 32'h0000_0000, 1'b0, 4'd2},  // R2 arm
      {1'b1, 4'd1, 32'h0000_1234, 4'd1, 32'h0000_1234, 1'b0, 4'd3},  // R3 accepted
      {1'b1, 4'd1, 32'h0000_5678, 4'd1, 32'h0000_1234, 1'b0, 4'd4},  // R4 used up
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h0000_1234, 1'b0, 4'd2},
      {1'b1, 4'd7, 32'h0000_0000, 4'd1, 32'h0000_1234, 1'b0, 4'd4},  // R4 unused addr
      {1'b1, 4'd1, 32'h0000_FFFF, 4'd1, 32'h0000_1234, 1'b0, 4'd4},
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h0000_1234, 1'b0, 4'd2},
      {1'b1, 4'd0, 32'h0000_0055, 4'd1, 32'h0000_1234, 1'b0, 4'd5},  // R5 wrong key
      {1'b1, 4'd1, 32'h0000_0001, 4'd1, 32'h0000_1234, 1'b0, 4'd5},
      {1'b1, 4'd0, 32'h0000_01AA, 4'd1, 32'h0000_1234, 1'b0, 4'd5},  // R5 full word
      {1'b1, 4'd1, 32'h0000_0002, 4'd1, 32'h0000_1234, 1'b0, 4'd5},
      {1'b1, 4'd0, 32'h0000_00AA, 4'd2, 32'h0000_0000, 1'b0, 4'd2},
      {1'b1, 4'd2, 32'h0000_00C3, 4'd2, 32'h0000_00C3, 1'b0, 4'd6},  // R6 accepted
      {1'b1, 4'd2, 32'h0000_0011, 4'd2, 32'h0000_00C3, 1'b0, 4'd6},  // R6 no key
      {1'b1, 4'd3, 32'hFFFF_FFFF, 4'd3, 32'hA000_0000, 1'b0, 4'd7},  // R7
      {1'b1, 4'd0, 32'h0000_00AA, 4'd3, 32'hA000_0000, 1'b0, 4'd7},
      {1'b1, 4'd3, 32'h0000_0000, 4'd3, 32'hA000_0000, 1'b0, 4'd7},
      {1'b1, 4'd1, 32'h0000_0005, 4'd1, 32'h0000_1234, 1'b0, 4'd4},  // R4 sys write used key
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h0000_1234, 1'b0, 4'd2},
      {1'b1, 4'd1, 32'h8000_1234, 4'd1, 32'h8000_1234, 1'b0, 4'd8},  // R8 set
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h8000_1234, 1'b0, 4'd2},
      {1'b1, 4'd1, 32'h8000_0001, 4'd1, 32'h8000_0001, 1'b0, 4'd8},  // R8 hold 1
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h8000_0001, 1'b0, 4'd2},
      {1'b1, 4'd1, 32'h0000_0001, 4'd1, 32'h0000_0001, 1'b1, 4'd8},  // R8 fall
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h0000_0001, 1'b0, 4'd2},
      {1'b1, 4'd1, 32'h0000_0002, 4'd1, 32'h0000_0002, 1'b0, 4'd8},  // R8 hold 0
      {1'b1, 4'd0, 32'h0000_00AA, 4'd1, 32'h0000_0002, 1'b0, 4'd2},
      {1'b0, 4'd1, 32'h0000_0000, 4'd1, 32'h0000_0002, 1'b0, 4'd9},  // R9 read
      {1'b0, 4'd2, 32'h0000_0000, 4'd2, 32'h0000_00C3, 1'b0, 4'd9},  // R9 read
      {1'b1, 4'd1, 32'h0000_0077, 4'd1, 32'h0000_0077, 1'b0, 4'd9},  // R9 still armed
      {1'b0, 4'd0, 32'h0000_0000, 4'd0, 32'h0000_0000, 1'b0, 4'd10}, // R10 key slot
      {1'b0, 4'd9, 32'h0000_0000, 4'd9, 32'h0000_0000, 1'b0, 4'd10}, // R10 unused
      {1'b0, 4'd2, 32'h0000_0000, 4'd2, 32'h0000_00C3, 1'b0, 4'd10}  // R10
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] v;
      logic          rq;
      repeat (3) @(negedge clk);
      // R1 reset values
      check(1, devcfg_o, 32'h0);
      check(1, audclk_o, 32'h0);
      check(1, {31'h0, rst_req_o}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         @(negedge clk);
         bus_we = v[77]; bus_addr = v[76:73]; bus_wdata = v[72:41];
         @(negedge clk);
         rq = rst_req_o;
         bus_we = 1'b0; bus_addr = v[40:37];
         #1;
         check(int'(v[3:0]), bus_rdata, v[36:5]);
         check(int'(v[3:0]), {31'h0, rq}, {31'h0, v[4]});
      end

      // R10 ports match stored words
      check(10, devcfg_o, 32'h0000_0077);
      check(10, audclk_o, 32'h0000_00C3);

      // R8 request lasts one cycle only
      bus_write(4'd0, 32'hAA);
      bus_write(4'd1, 32'h8000_0000);
      bus_write(4'd0, 32'hAA);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h0;
      @(negedge clk);
      bus_we = 1'b0;
      check(8, {31'h0, rst_req_o}, 32'h1);
      @(negedge clk);
      check(8, {31'h0, rst_req_o}, 32'h0);

      // R1 reset clears a pending unlock and restores words
      bus_write(4'd0, 32'hAA);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, devcfg_o, 32'h0);
      check(1, audclk_o, 32'h0);
      rst_n = 1'b1;
      bus_write(4'd1, 32'h0000_4444);
      bus_addr = 4'd1; #1;
      check(1, bus_rdata, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule